// File: doc/BRIEF.md
# Staggered-Phase Pulse Timestamper

This block gives a fine timestamp to each hit pulse, counted from the most recent sync pulse. It does not use one fast binary counter. It runs NPH identical coarse counters, and each counter is clocked by its own copy of a slow clock. The copies are equally spaced in phase across one period. A sync pulse clears every counter. A hit pulse makes every phase domain capture its own count.

The captured counts cross into a readout clock domain and are added together. Between them the staggered counters see every 1/NPH step of the clock period, so the sum is a timestamp with a resolution of the period divided by NPH. For example, 4 phases at 250 MHz give 1 ns steps, and 8 phases at 125 MHz give the same.

The phase counts are also compared with each other. If they spread by more than one count, the sample was spoiled by an aperture or metastability violation, and the record is flagged. The phase clocks are primary inputs. A host drains the finished records through a valid/ready port.

Top module: `phase_stamp_capture`

## Requirements
- R1: `out_ts` is the number of rising edges, taken across all phase clocks together, that fall after the sync rising edge and at or before the hit rising edge.
- R2: A sync pulse restarts the count, so every later hit is measured from it. This holds even for a hit that rises one or two readout cycles after the sync.
- R3: Several hits after one sync, with no new sync between them, are all measured from that same sync.
- R4: `out_err` is 1 when the largest and smallest captured phase counts differ by more than one, and 0 otherwise.
- R5: When the edge count reaches 2^TSW or more, `out_ovf` is 1 and `out_ts` holds the count modulo 2^TSW. Below that, `out_ovf` is 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, the record (`out_ts`, `out_err`, `out_ovf`) stays unchanged and `out_valid` stays 1.
- R7: A hit whose record completes while the held record has not been accepted is dropped. It sets `lost`, which stays 1 until reset.
- R8: While reset is applied and just after it is released, `out_valid` and `lost` are 0.
- R9: After a record is accepted (`out_valid` and `out_ready` both high at a readout edge), `out_valid` is 0 unless a new record completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous active-high reset for all domains |
| ph_clk | input | NPH | Phase-staggered copies of the counting clock |
| sync_in | input | 1 | Sync pulse; its rising edge restarts the timebase |
| hit_in | input | 1 | Event pulse; its rising edge is timestamped |
| rd_clk | input | 1 | Readout clock |
| out_valid | output | 1 | A record is held for the host |
| out_ready | input | 1 | Host accepts the held record |
| out_ts | output | TSW | Timestamp in fine steps since sync |
| out_err | output | 1 | Phase counts spread by more than one |
| out_ovf | output | 1 | Count exceeded the timestamp range |
| lost | output | 1 | Sticky: a record was dropped |

## Verification
Suppose one phase counter misses a clear or drifts by even a single step. The summed `out_ts` of the very next record then moves off the expected edge count, and this shows about fifteen readout cycles after the hit edge. A phase domain that stops capturing entirely never completes a record, so `out_valid` stays low where a record was due. A bad slot state shows up in two ways: a held record changes under back-pressure, or `lost` rises or falls at the wrong time. Either is visible in the same cycle.

// File: rtl/phase_stamp_capture.sv
`timescale 1ns/1ps
module phase_stamp_capture #(
  parameter int NPH = 4,
  parameter int TSW = 32
) (
  input  logic           rst,
  input  logic [NPH-1:0] ph_clk,
  input  logic           sync_in,
  input  logic           hit_in,
  input  logic           rd_clk,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [TSW-1:0] out_ts,
  output logic           out_err,
  output logic           out_ovf,
  output logic           lost
);
  localparam int LN = $clog2(NPH) + 1;
  localparam int SW = TSW + LN;

  logic [TSW-1:0] rv [NPH];
  logic [NPH-1:0] rw, got;
  logic           take;

  for (genvar g = 0; g < NPH; g++) begin : gph
    logic [2:0]     s, h, rq;
    logic [TSW-1:0] cnt, cap, val;
    logic [TSW:0]   nxt;
    logic           wr, capw, req, vw, have, sdet, hdet;

    assign sdet = s[1] & ~s[2];
    assign hdet = h[1] & ~h[2];
    assign nxt  = {1'b0, cnt} + (TSW+1)'(1);

    always_ff @(posedge ph_clk[g] or posedge rst)
      if (rst) begin
        s <= '0; h <= '0; cnt <= '0; wr <= 1'b0;
        cap <= '0; capw <= 1'b0; req <= 1'b0;
      end else begin
        s <= {s[1:0], sync_in};
        h <= {h[1:0], hit_in};
        if (sdet) begin
          cnt <= '0;
          wr  <= 1'b0;
        end else begin
          cnt <= nxt[TSW-1:0];
          if (nxt[TSW]) wr <= 1'b1;
        end
        if (hdet) begin
          cap  <= sdet ? '0 : nxt[TSW-1:0];
          capw <= ~sdet & (wr | nxt[TSW]);
          req  <= ~req;
        end
      end

    always_ff @(posedge rd_clk or posedge rst)
      if (rst) begin
        rq <= '0; val <= '0; vw <= 1'b0; have <= 1'b0;
      end else begin
        rq <= {rq[1:0], req};
        if (rq[1] ^ rq[2]) begin
          val  <= cap;
          vw   <= capw;
          have <= 1'b1;
        end else if (take) begin
          have <= 1'b0;
        end
      end

    assign rv[g]  = val;
    assign rw[g]  = vw;
    assign got[g] = have;
  end

  assign take = &got;

  logic [SW-1:0]  sum;
  logic [TSW-1:0] mx, mn;
  always_comb begin
    sum = '0;
    mx  = rv[0];
    mn  = rv[0];
    for (int k = 0; k < NPH; k++) begin
      sum = sum + SW'(rv[k]);
      if (rv[k] > mx) mx = rv[k];
      if (rv[k] < mn) mn = rv[k];
    end
  end

  logic spread, wide;
  assign spread = (mx - mn) > TSW'(1);
  assign wide   = (|rw) | (sum[SW-1:TSW] != '0);

  always_ff @(posedge rd_clk or posedge rst)
    if (rst) begin
      out_valid <= 1'b0; out_ts <= '0; out_err <= 1'b0;
      out_ovf <= 1'b0; lost <= 1'b0;
    end else if (take) begin
      if (!out_valid || out_ready) begin
        out_valid <= 1'b1;
        out_ts    <= sum[TSW-1:0];
        out_err   <= spread;
        out_ovf   <= wide;
      end else begin
        lost <= 1'b1;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
endmodule

// File: rtl/phase_stamp_capture_chk.sv
`timescale 1ns/1ps
module phase_stamp_capture_chk #(
  parameter int TSW = 32
) (
  input logic           rd_clk,
  input logic           rst,
  input logic           out_valid,
  input logic           out_ready,
  input logic [TSW-1:0] out_ts,
  input logic           out_err,
  input logic           out_ovf,
  input logic           lost
);
  // R6
  hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_ts) && $stable(out_err) && $stable(out_ovf));

  // R7
  lost_sticky_chk: assert property (@(posedge rd_clk) disable iff (rst)
    lost |=> lost);

  // R7
  lost_cause_chk: assert property (@(posedge rd_clk) disable iff (rst)
    $rose(lost) |-> $past(out_valid && !out_ready));

  // R8
  reset_state_chk: assert property (@(posedge rd_clk)
    $fell(rst) |-> !out_valid && !lost);
endmodule

bind phase_stamp_capture phase_stamp_capture_chk #(.TSW(TSW)) u_chk (
  .rd_clk(rd_clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_ts(out_ts), .out_err(out_err), .out_ovf(out_ovf), .lost(lost));

// File: tb/sim_phase_stamp_capture.sv
`timescale 1ns/1ps
module sim_phase_stamp_capture;
  localparam int NPH = 4;
  localparam int TSW = 10;

  logic rd_clk = 1'b0;
  always #5 rd_clk = ~rd_clk;

  logic           rst = 1'b1, sync_in = 1'b0, hit_in = 1'b0, out_ready = 1'b1;
  logic [NPH-1:0] ph_en = '1;
  wire  [NPH-1:0] ph_clk;
  logic           out_valid, out_err, out_ovf, lost;
  logic [TSW-1:0] out_ts;

  for (genvar k = 0; k < NPH; k++) begin : gclk
    logic c = 1'b0;
    initial begin
      #(2 + 10*k);
      forever begin
        c = ph_en[k];
        #20;
        c = 1'b0;
        #20;
      end
    end
    assign ph_clk[k] = c;
  end

  phase_stamp_capture #(.NPH(NPH), .TSW(TSW)) u0 (
    .rst(rst), .ph_clk(ph_clk), .sync_in(sync_in), .hit_in(hit_in),
    .rd_clk(rd_clk), .out_valid(out_valid), .out_ready(out_ready),
    .out_ts(out_ts), .out_err(out_err), .out_ovf(out_ovf), .lost(lost));

  int nvec = 0, nbad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {sync-to-hit readout cycles, ts, err, ovf}; one cycle = one fine step
  localparam int NV = 10;
  localparam int V [NV][4] = '{
    '{1, 1, 0, 0},        // R2 hit one cycle after sync
    '{2, 2, 0, 0},        // R2 hit two cycles after sync
    '{7, 7, 0, 0},
    '{8, 8, 0, 0},
    '{57, 57, 0, 0},
    '{333, 333, 0, 0},
    '{1000, 1000, 0, 0},
    '{1023, 1023, 0, 0},  // R5 last count in range
    '{1024, 0, 0, 1},     // R5 first overflowing count
    '{1500, 476, 0, 1}    // R5 wrapped value
  };

  task automatic send(input int c);
    @(negedge rd_clk) sync_in = 1'b1;
    for (int i = 1; i <= c + 8; i++) begin
      @(negedge rd_clk);
      if (i == 8) sync_in = 1'b0;
      if (i == c) hit_in = 1'b1;
      if (i == c + 8) hit_in = 1'b0;
    end
  endtask

  task automatic wait_rec();
    for (int i = 0; i < 300 && !out_valid; i++) @(negedge rd_clk);
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int n, a, b;
    repeat (5) @(negedge rd_clk);
    chk("R8 valid in reset", out_valid, 0);
    chk("R8 lost in reset", lost, 0);
    rst = 1'b0;
    @(negedge rd_clk);
    chk("R8 valid after reset", out_valid, 0);

    for (int v = 0; v < NV; v++) begin
      send(V[v][0]);
      wait_rec();
      chk("R1 record present", out_valid, 1);
      chk("R1 ts", out_ts, V[v][1]);
      chk("R4 err clean", out_err, V[v][2]);
      chk("R5 ovf", out_ovf, V[v][3]);
      @(negedge rd_clk);
      chk("R9 valid after accept", out_valid, 0);
      repeat (5) @(negedge rd_clk);
    end

    // R3 two hits after one sync
    n = 0; a = -1; b = -1;
    @(negedge rd_clk) sync_in = 1'b1;
    for (int i = 1; i <= 110; i++) begin
      @(negedge rd_clk);
      if (out_valid) begin
        if (n == 0) a = out_ts; else b = out_ts;
        n++;
      end
      if (i == 8) sync_in = 1'b0;
      if (i == 20 || i == 60) hit_in = 1'b1;
      if (i == 28 || i == 68) hit_in = 1'b0;
    end
    chk("R3 record count", n, 2);
    chk("R3 first hit", a, 20);
    chk("R3 second hit", b, 60);

    // R4 phase 2 misses five of its edges
    @(negedge rd_clk) sync_in = 1'b1;
    for (int i = 1; i <= 108; i++) begin
      @(negedge rd_clk);
      if (i == 8) sync_in = 1'b0;
      if (i == 10) ph_en[2] = 1'b0;
      if (i == 30) ph_en[2] = 1'b1;
      if (i == 100) hit_in = 1'b1;
      if (i == 108) hit_in = 1'b0;
    end
    wait_rec();
    chk("R4 ts with gap", out_ts, 95);
    chk("R4 err flagged", out_err, 1);
    chk("R5 no ovf", out_ovf, 0);
    repeat (5) @(negedge rd_clk);

    // R6/R7 back-pressure
    out_ready = 1'b0;
    send(30);
    wait_rec();
    chk("R6 held ts", out_ts, 30);
    chk("R7 lost before drop", lost, 0);
    repeat (20) @(negedge rd_clk);
    hit_in = 1'b1;
    repeat (8) @(negedge rd_clk);
    hit_in = 1'b0;
    repeat (40) @(negedge rd_clk);
    chk("R7 lost set", lost, 1);
    chk("R6 still valid", out_valid, 1);
    chk("R6 ts unchanged", out_ts, 30);
    out_ready = 1'b1;
    @(negedge rd_clk);
    chk("R9 valid after accept", out_valid, 0);
    repeat (40) @(negedge rd_clk);
    chk("R7 dropped record absent", out_valid, 0);
    chk("R7 lost sticky", lost, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule